// File: doc/BRIEF.md
# Single-Step Accumulator Processor

This block is a small accumulator machine that carries out one instruction for each step strobe. There is no program counter and no instruction memory. Whatever drives the inputs puts a 14-bit instruction word on `instrWord`, raises `stepStrobe` for one clock cycle, and the instruction takes effect on that clock edge. The design holds an 8-bit accumulator, three 8-bit general registers and an 8-bit display register. It also has a flag that reports whether the display has been written since reset.

Each opcode selects one entry of a 16-entry control table. The entry is an 11-bit control word. Four one-hot enables in it choose the source of an internal byte bus: the immediate field, the selected register, the accumulator or the ALU. Three one-hot bits choose the ALU function. The remaining bits are load enables for the accumulator, the selected register and the display. The accumulator is also brought out on a debug port.

Top module: `stepcpu_top`

## Requirements
- R1: State (accumulator, registers, display, display-valid) changes only on a rising clock edge where `stepStrobe` is 1. With the strobe at 0 every instruction is ignored.
- R2: While `rst` is 1 at a clock edge, the accumulator, all three registers and the display are cleared to 0 and `dispValid` goes to 0. Reset takes priority over the strobe.
- R3: Instruction fields are taken from fixed bit positions: opcode from bits [13:10], register select from bits [9:8], immediate byte from bits [7:0]. Select 01, 10 and 11 address registers one, two and three.
- R4: Opcode 1111 writes the immediate byte into the selected register and leaves every other register and the accumulator unchanged. Opcode 1110 writes the immediate byte into the accumulator.
- R5: Opcode 0011 copies the selected register into the accumulator. Opcode 0010 copies the accumulator into the selected register.
- R6: Opcode 1011 copies the selected register into the display, and opcode 1010 copies the accumulator into the display. No other opcode changes the display.
- R7: Opcode 0101 sets the accumulator to (accumulator + register) mod 256. Opcode 0110 sets it to (accumulator − register) mod 256.
- R8: Opcode 0111 sets the accumulator to the product of the low four bits of the accumulator and the low four bits of the selected register, as an 8-bit result.
- R9: Select code 00 addresses no register. Writes aimed at it change nothing, and reads through it give 0.
- R10: The opcodes 0000, 0001, 0100, 1000, 1001, 1100 and 1101 change no state.
- R11: `dispValid` becomes 1 with the first executed 1011 or 1010 after reset and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stepStrobe | input | 1 | One-cycle pulse that executes `instrWord` |
| instrWord | input | 14 | Instruction: opcode, register select, immediate |
| dispValue | output | 8 | Display register |
| dispValid | output | 1 | Display has been written since reset |
| accView | output | 8 | Debug copy of the accumulator |

## Verification
A wrong accumulator value shows on `accView` right after the edge that executes the instruction. A bad register value stays hidden until an instruction reads that register. For that reason, after every instruction under test the bench reads all three registers out through the display, so a stray write or a missing write is caught within a few steps. A corrupted control table entry shows up as a wrong accumulator, display or register value on the step that uses that opcode with every select code. A display or valid flag that moves when it should not is seen on the very next sample.

// File: rtl/stepcpu_pkg.sv
package stepcpu_pkg;
  localparam int OPC_W   = 4;
  localparam int SEL_W   = 2;
  localparam int DATA_W  = 8;
  localparam int NUM_GPR = 3;
  localparam int WORD_W  = OPC_W + SEL_W + DATA_W;
  localparam int NUM_OPC = 1 << OPC_W;
  localparam int MUL_W   = DATA_W / 2;

  localparam logic [OPC_W-1:0] OP_IMM_GPR = 4'b1111;
  localparam logic [OPC_W-1:0] OP_IMM_ACC = 4'b1110;
  localparam logic [OPC_W-1:0] OP_SHOW_GPR = 4'b1011;
  localparam logic [OPC_W-1:0] OP_SHOW_ACC = 4'b1010;
  localparam logic [OPC_W-1:0] OP_GPR_TO_ACC = 4'b0011;
  localparam logic [OPC_W-1:0] OP_ACC_TO_GPR = 4'b0010;
  localparam logic [OPC_W-1:0] OP_ADD = 4'b0101;
  localparam logic [OPC_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OPC_W-1:0] OP_MUL = 4'b0111;

  // 11-bit control word: bus source enables, ALU function, load enables
  typedef struct packed {
    logic srcImm;
    logic srcGpr;
    logic srcAcc;
    logic srcAlu;
    logic fnAdd;
    logic fnSub;
    logic fnMul;
    logic loadAcc;
    logic loadGpr;
    logic loadDisp;
    logic markShow;
  } ctrlWord_t;

  function automatic ctrlWord_t decodeOp(input logic [OPC_W-1:0] op);
    ctrlWord_t c;
    c = '0;
    unique case (op)
      OP_IMM_GPR:    begin c.srcImm = 1'b1; c.loadGpr = 1'b1; end
      OP_IMM_ACC:    begin c.srcImm = 1'b1; c.loadAcc = 1'b1; end
      OP_SHOW_GPR:   begin c.srcGpr = 1'b1; c.loadDisp = 1'b1; c.markShow = 1'b1; end
      OP_SHOW_ACC:   begin c.srcAcc = 1'b1; c.loadDisp = 1'b1; c.markShow = 1'b1; end
      OP_GPR_TO_ACC: begin c.srcGpr = 1'b1; c.loadAcc = 1'b1; end
      OP_ACC_TO_GPR: begin c.srcAcc = 1'b1; c.loadGpr = 1'b1; end
      OP_ADD:        begin c.srcAlu = 1'b1; c.fnAdd = 1'b1; c.loadAcc = 1'b1; end
      OP_SUB:        begin c.srcAlu = 1'b1; c.fnSub = 1'b1; c.loadAcc = 1'b1; end
      OP_MUL:        begin c.srcAlu = 1'b1; c.fnMul = 1'b1; c.loadAcc = 1'b1; end
      default:       c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/stepcpu_ctrl.sv
module stepcpu_ctrl
  import stepcpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stepStrobe,
  input  logic [OPC_W-1:0] opcode,
  output ctrlWord_t        strb
);
  ctrlWord_t ctrlRom [NUM_OPC];

  generate
    for (genvar i = 0; i < NUM_OPC; i++) begin : g_rom
      assign ctrlRom[i] = decodeOp(OPC_W'(i));
    end
  endgenerate

  always_comb begin
    strb = '0;
    if (stepStrobe) strb = ctrlRom[opcode];
  end

  AST_IDLE_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
    !stepStrobe |-> (strb == '0)); // R1
  AST_ONE_BUS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.srcImm, strb.srcGpr, strb.srcAcc, strb.srcAlu})); // R4
  AST_ONE_DESTINATION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadAcc, strb.loadGpr, strb.loadDisp})); // R6
  AST_ALU_FEEDS_ACC: assert property (@(posedge clk) disable iff (rst)
    strb.srcAlu |-> (strb.loadAcc && $onehot({strb.fnAdd, strb.fnSub, strb.fnMul}))); // R7
endmodule

// File: rtl/stepcpu_datapath.sv
module stepcpu_datapath
  import stepcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlWord_t         strb,
  input  logic [SEL_W-1:0]  gprSel,
  input  logic [DATA_W-1:0] immData,
  output logic [DATA_W-1:0] dispValue,
  output logic              dispValid,
  output logic [DATA_W-1:0] accView
);
  localparam int GPR_SLOTS = 1 << SEL_W;

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] dispQ;
  logic              validQ;
  logic [DATA_W-1:0] gprQ [GPR_SLOTS];
  logic [DATA_W-1:0] gprRd;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] mulA;
  logic [DATA_W-1:0] mulB;
  logic [DATA_W-1:0] busVal;

  // slot 0 is the null register: reads zero, never written
  assign gprQ[0] = '0;

  generate
    for (genvar i = 1; i < GPR_SLOTS; i++) begin : g_gpr
      if (i <= NUM_GPR) begin : g_real
        always_ff @(posedge clk) begin
          if (rst) gprQ[i] <= '0;
          else if (strb.loadGpr && (gprSel == SEL_W'(i))) gprQ[i] <= busVal;
        end
        AST_GPR_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
          !(strb.loadGpr && (gprSel == SEL_W'(i))) |=> $stable(gprQ[i])); // R4
      end else begin : g_absent
        assign gprQ[i] = '0;
      end
    end
  endgenerate

  assign gprRd = gprQ[gprSel];

  assign mulA = {{(DATA_W-MUL_W){1'b0}}, accQ[MUL_W-1:0]};
  assign mulB = {{(DATA_W-MUL_W){1'b0}}, gprRd[MUL_W-1:0]};

  always_comb begin
    aluOut = '0;
    if (strb.fnAdd)      aluOut = accQ + gprRd;
    else if (strb.fnSub) aluOut = accQ - gprRd;
    else if (strb.fnMul) aluOut = mulA * mulB;
  end

  // wired-OR bus of gated sources
  assign busVal = ({DATA_W{strb.srcImm}} & immData)
                | ({DATA_W{strb.srcGpr}} & gprRd)
                | ({DATA_W{strb.srcAcc}} & accQ)
                | ({DATA_W{strb.srcAlu}} & aluOut);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ   <= '0;
      dispQ  <= '0;
      validQ <= 1'b0;
    end else begin
      if (strb.loadAcc)  accQ  <= busVal;
      if (strb.loadDisp) dispQ <= busVal;
      if (strb.markShow) validQ <= 1'b1;
    end
  end

  assign dispValue = dispQ;
  assign dispValid = validQ;
  assign accView   = accQ;

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.loadAcc |=> $stable(accQ)); // R10
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.loadDisp |=> $stable(dispQ)); // R6
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    validQ |=> validQ); // R11
  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.srcGpr && gprSel == '0) |-> (busVal == '0)); // R9
endmodule

// File: rtl/stepcpu_top.sv
module stepcpu_top
  import stepcpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stepStrobe,
  input  logic [WORD_W-1:0] instrWord,
  output logic [DATA_W-1:0] dispValue,
  output logic              dispValid,
  output logic [DATA_W-1:0] accView
);
  localparam int OPC_LSB = SEL_W + DATA_W;

  ctrlWord_t         strb;
  logic [OPC_W-1:0]  opcode;
  logic [SEL_W-1:0]  gprSel;
  logic [DATA_W-1:0] immData;

  assign opcode  = instrWord[WORD_W-1:OPC_LSB];
  assign gprSel  = instrWord[OPC_LSB-1:DATA_W];
  assign immData = instrWord[DATA_W-1:0];

  stepcpu_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stepStrobe (stepStrobe),
    .opcode     (opcode),
    .strb       (strb)
  );

  stepcpu_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .gprSel    (gprSel),
    .immData   (immData),
    .dispValue (dispValue),
    .dispValid (dispValid),
    .accView   (accView)
  );
endmodule

// File: tb/stepcpu_top_bench.sv
`timescale 1ns/1ps
module stepcpu_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stepStrobe = 1'b0;
  logic [13:0] instrWord = '0;
  logic [7:0]  dispValue;
  logic        dispValid;
  logic [7:0]  accView;

  int testsRun = 0;
  int testsFailed = 0;

  logic [7:0] mAcc;
  logic [7:0] mDisp;
  logic       mValid;
  logic [7:0] mReg [4];

  always #2.5 clk = ~clk;

  stepcpu_top u_stepcpu_top (
    .clk(clk), .rst(rst), .stepStrobe(stepStrobe), .instrWord(instrWord),
    .dispValue(dispValue), .dispValid(dispValid), .accView(accView)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string reqFor(input logic [3:0] op, input logic [1:0] sel);
    string r;
    case (op)
      4'b1111, 4'b1110: r = "R4";
      4'b0011, 4'b0010: r = "R5";
      4'b1011, 4'b1010: r = "R6";
      4'b0101, 4'b0110: r = "R7";
      4'b0111:          r = "R8";
      default:          r = "R10";
    endcase
    if (sel == 2'b00 && r != "R10") r = "R9";
    return r;
  endfunction

  task automatic modelStep(input logic [3:0] op, input logic [1:0] sel, input logic [7:0] imm);
    logic [7:0] rd;
    rd = (sel == 2'b00) ? 8'h00 : mReg[sel];
    case (op)
      4'b1111: if (sel != 2'b00) mReg[sel] = imm;
      4'b1110: mAcc = imm;
      4'b1011: begin mDisp = rd; mValid = 1'b1; end
      4'b1010: begin mDisp = mAcc; mValid = 1'b1; end
      4'b0011: mAcc = rd;
      4'b0010: if (sel != 2'b00) mReg[sel] = mAcc;
      4'b0101: mAcc = mAcc + rd;
      4'b0110: mAcc = mAcc - rd;
      4'b0111: mAcc = {4'b0, mAcc[3:0]} * {4'b0, rd[3:0]};
      default: ;
    endcase
  endtask

  task automatic exec(input logic [3:0] op, input logic [1:0] sel, input logic [7:0] imm);
    @(negedge clk);
    instrWord = {op, sel, imm};
    stepStrobe = 1'b1;
    @(negedge clk);
    stepStrobe = 1'b0;
    modelStep(op, sel, imm);
  endtask

  task automatic checkState(input string req);
    chk(req, "acc", accView, mAcc);
    chk(req, "display", dispValue, mDisp);
    chk(req, "valid", {7'b0, dispValid}, {7'b0, mValid});
  endtask

  task automatic peekRegs();
    for (int r = 1; r < 4; r++) begin
      exec(4'b1011, 2'(r), 8'h00);
      chk("R3", "register readout", dispValue, mReg[r]);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    stepStrobe = 1'b1;
    instrWord = {4'b1110, 2'b00, 8'hEE};
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    stepStrobe = 1'b0;
    mAcc = '0; mDisp = '0; mValid = 1'b0;
    for (int r = 0; r < 4; r++) mReg[r] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    doReset();
    checkState("R2");
    chk("R11", "valid after reset", {7'b0, dispValid}, 8'h00);

    // R1: instruction held without strobe does nothing
    exec(4'b1110, 2'b00, 8'h3C);
    @(negedge clk);
    instrWord = {4'b1110, 2'b00, 8'hA5};
    repeat (4) @(negedge clk);
    chk("R1", "acc without strobe", accView, 8'h3C);
    instrWord = {4'b1010, 2'b00, 8'h00};
    repeat (3) @(negedge clk);
    chk("R1", "valid without strobe", {7'b0, dispValid}, 8'h00);
    checkState("R1");

    // near-exhaustive sweep: every opcode, every select, several operands
    for (int op = 0; op < 16; op++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int k = 0; k < 3; k++) begin
          for (int r = 1; r < 4; r++)
            exec(4'b1111, 2'(r), 8'(91 * r + 53 * k + sel + op));
          exec(4'b1110, 2'b00, 8'(37 * k + 200 + op));
          exec(4'(op), 2'(sel), 8'(77 * k + 13));
          checkState(reqFor(4'(op), 2'(sel)));
          peekRegs();
        end
      end
    end
    chk("R11", "valid stays set", {7'b0, dispValid}, 8'h01);

    // R2: reset clears everything even with strobe high
    doReset();
    checkState("R2");
    peekRegs();
    chk("R2", "register one after reset", mReg[1], 8'h00);

    // R8: largest nibble product and high bits ignored
    exec(4'b1111, 2'b10, 8'hAF);
    exec(4'b1110, 2'b00, 8'h7F);
    exec(4'b0111, 2'b10, 8'h00);
    chk("R8", "15*15", accView, 8'd225);
    // R7: wrap-around
    exec(4'b1111, 2'b01, 8'hFF);
    exec(4'b0101, 2'b01, 8'h00);
    chk("R7", "add wrap", accView, 8'(225 + 255));
    exec(4'b1110, 2'b00, 8'h01);
    exec(4'b0110, 2'b01, 8'h00);
    chk("R7", "sub wrap", accView, 8'h02);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule